// File: doc/BRIEF.md
# Masked Search Memory with Command Decoder

This block is a small content-addressable memory. It holds sixteen 32-bit words, and each word carries an empty flag. A single command port, sampled once per clock, selects one operation. The operations are: compare a search word against every occupied entry, read or write at an internal address register, read or write at the best match, write into the first empty slot, report that slot's index, load or read the address register, load a mask register, and do nothing. The lowest index always has the highest priority.

Every write that changes stored data or the address register can be limited bit by bit through one of seven mask registers, which the command selects. Mask selector zero means the whole word is written. Read results appear one clock after the command on a registered data output. A separate enable flag marks when that data is meaningful, and it stays low when the command has nothing to return. The page number reported with the free-slot index comes from a static input.

Top module: `tcam_cmd`

## Requirements
- R1: After reset every entry is empty, all mask registers and the address register are zero, the match vector is clear, and `rd_oe`, `match_flag` and `full` are low.
- R2: Opcode 11 loads mask register `cmd_msel` from `cmd_data`, and does nothing when `cmd_msel` is 0. On a masked write, a data bit is updated only where the selected mask bit is 0. Selector 0 applies no mask.
- R3: A write to an array entry sets that entry occupied when `vb_n` is 0 and empty when `vb_n` is 1.
- R4: Opcode 2 returns the entry at the address register on `rd_data`, returns that entry's empty flag on `rd_empty` (1 = empty), and then decrements the address register modulo 16. Opcode 3 writes the entry at the address register, with masking, and leaves the address register unchanged.
- R5: Opcode 1 sets the match vector to the occupied entries that equal `cmd_data`. `match_flag` is high when any bit is set, and `match_addr` gives the lowest set index.
- R6: Opcode 4 returns the entry at `match_addr` with `rd_oe` high. When no match is pending, `rd_oe` stays low.
- R7: Opcode 5 behaves like opcode 4 and also removes the current best match from the vector, so the next match becomes current. `match_flag` drops once no matches remain.
- R8: The free slot is the lowest empty index, and `full` is high when no entry is empty. Opcode 7 writes the masked data there. When the array is full, opcode 7 changes nothing.
- R9: Opcode 8 returns the free-slot index on bits 11:0, `page_id` on bits 15:12 and zero on bits 31:16. When the array is full, `rd_oe` stays low.
- R10: Opcode 9 loads the address register from `cmd_data[3:0]`, masked with the low bits of the selected mask register. Opcode 10 returns the address register, zero-extended.
- R11: Opcode 0, opcodes 12 to 15 and idle cycles (`cmd_valid` low) change no state and leave `rd_oe` low.
- R12: Opcode 6 writes the masked data at `match_addr` when a match is pending and does nothing otherwise. Writes never recompute the match vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Operation code |
| cmd_msel | input | 3 | Mask register selector |
| cmd_data | input | 32 | Write data, search word or address value |
| vb_n | input | 1 | Empty flag for the written entry (0 = occupied) |
| page_id | input | 4 | Constant page number for free-slot reads |
| rd_data | output | 32 | Registered read result |
| rd_oe | output | 1 | Read result is valid |
| rd_empty | output | 1 | Empty flag of the entry read by opcode 2 |
| match_flag | output | 1 | A match is pending |
| match_addr | output | 4 | Index of the best pending match |
| full | output | 1 | No empty entry remains |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- Duplicate words. A compare on a word stored twice must report the lower index first, and a step must then move to the higher one. An encoder with reversed priority, or a step that clears the wrong bit, would report the wrong address.
- Empty entries holding a matching word. These must stay out of the vector. A design that ignored the empty flag would raise `match_flag` for stale contents.
- Address register wrap. Reading past index 0 must wrap to 15.
- Full array. Writes into a full array must leave every entry intact, and a free-slot read must drop `rd_oe`.
- Masked writes. Both fully masked and unmasked selectors are driven, so a mask with inverted sense would corrupt the kept bits.

// File: rtl/tcam_cmd.sv
module tcam_cmd #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 32,
  parameter int MSEL_W = 3,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [MSEL_W-1:0] cmd_msel,
  input  logic [WIDTH-1:0]  cmd_data,
  input  logic              vb_n,
  input  logic [PAGE_W-1:0] page_id,
  output logic [WIDTH-1:0]  rd_data,
  output logic              rd_oe,
  output logic              rd_empty,
  output logic              match_flag,
  output logic [$clog2(DEPTH)-1:0] match_addr,
  output logic              full
);
  localparam int AW    = $clog2(DEPTH);
  localparam int NMASK = 1 << MSEL_W;

  localparam logic [3:0] OP_CMP   = 4'd1;
  localparam logic [3:0] OP_RDAR  = 4'd2;
  localparam logic [3:0] OP_WRAR  = 4'd3;
  localparam logic [3:0] OP_RDHPM = 4'd4;
  localparam logic [3:0] OP_RDNXT = 4'd5;
  localparam logic [3:0] OP_WRHPM = 4'd6;
  localparam logic [3:0] OP_WRNFA = 4'd7;
  localparam logic [3:0] OP_RDNFA = 4'd8;
  localparam logic [3:0] OP_WRADR = 4'd9;
  localparam logic [3:0] OP_RDADR = 4'd10;
  localparam logic [3:0] OP_WRMSK = 4'd11;

  logic [WIDTH-1:0] mem   [DEPTH];
  logic [WIDTH-1:0] masks [NMASK];
  logic [DEPTH-1:0] occ, mvec;
  logic [AW-1:0]    ar, nfa;
  logic [WIDTH-1:0] wmask, wr_word;
  logic [AW-1:0]    wr_addr;
  logic             wr_en;

  function automatic logic [AW-1:0] first_set(input logic [DEPTH-1:0] v);
    first_set = '0;
    for (int i = DEPTH-1; i >= 0; i--)
      if (v[i]) first_set = AW'(i);
  endfunction

  assign match_flag = |mvec;
  assign match_addr = first_set(mvec);
  assign full       = &occ;
  assign nfa        = first_set(~occ);
  assign wmask      = (cmd_msel == '0) ? '0 : masks[cmd_msel];

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = ar;
    if (cmd_valid) begin
      case (cmd_op)
        OP_WRAR:  wr_en = 1'b1;
        OP_WRHPM: begin wr_en = match_flag; wr_addr = match_addr; end
        OP_WRNFA: begin wr_en = !full;      wr_addr = nfa;        end
        default:  wr_en = 1'b0;
      endcase
    end
  end

  assign wr_word = (mem[wr_addr] & wmask) | (cmd_data & ~wmask);

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ      <= '0;
      mvec     <= '0;
      ar       <= '0;
      rd_data  <= '0;
      rd_oe    <= 1'b0;
      rd_empty <= 1'b0;
      for (int i = 0; i < NMASK; i++) masks[i] <= '0;
    end else begin
      rd_oe    <= 1'b0;
      rd_empty <= 1'b0;
      if (wr_en) occ[wr_addr] <= !vb_n;
      if (cmd_valid) begin
        case (cmd_op)
          OP_CMP:
            for (int i = 0; i < DEPTH; i++)
              mvec[i] <= occ[i] && (mem[i] == cmd_data);
          OP_RDAR: begin
            rd_data  <= mem[ar];
            rd_empty <= !occ[ar];
            rd_oe    <= 1'b1;
            ar       <= ar - 1'b1;
          end
          OP_RDHPM, OP_RDNXT: begin
            rd_data <= mem[match_addr];
            rd_oe   <= match_flag;
            if (cmd_op == OP_RDNXT && match_flag) mvec[match_addr] <= 1'b0;
          end
          OP_RDNFA: begin
            rd_data <= '0;
            rd_data[11:0]  <= 12'(nfa);
            rd_data[15:12] <= 4'(page_id);
            rd_oe   <= !full;
          end
          OP_WRADR: ar <= (ar & wmask[AW-1:0]) | (cmd_data[AW-1:0] & ~wmask[AW-1:0]);
          OP_RDADR: begin
            rd_data <= WIDTH'(ar);
            rd_oe   <= 1'b1;
          end
          OP_WRMSK: if (cmd_msel != '0) masks[cmd_msel] <= cmd_data;
          default: ;
        endcase
      end
    end
  end

  logic past_live;
  always_ff @(posedge clk) past_live <= rst_n;

  p_rdar_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_live && cmd_valid && cmd_op == OP_RDAR) |=> (ar == $past(ar) - 1'b1));

  p_nomatch_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_live && cmd_valid && (cmd_op == OP_RDHPM || cmd_op == OP_RDNXT) && !match_flag) |=> !rd_oe);

  p_step_drops_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_live && cmd_valid && cmd_op == OP_RDNXT && match_flag)
      |=> ($countones(mvec) == $countones($past(mvec)) - 1));

  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_live && cmd_valid && cmd_op == OP_WRNFA && full) |=> $stable(occ));

  p_nop_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (past_live && (!cmd_valid || cmd_op == 4'd0 || cmd_op >= 4'd12))
      |=> ($stable(occ) && $stable(mvec) && $stable(ar) && !rd_oe));

  p_wr_keeps_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (past_live && cmd_valid && (cmd_op == OP_WRAR || cmd_op == OP_WRNFA || cmd_op == OP_WRHPM))
      |=> $stable(mvec));
endmodule

// File: tb/tcam_cmd_tb_top.sv
`timescale 1ns/1ps
module tcam_cmd_tb_top;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [3:0] cmd_op = 0;
  logic [2:0] cmd_msel = 0;
  logic [31:0] cmd_data = 0;
  logic vb_n = 0;
  logic [3:0] page_id = 4'hA;
  logic [31:0] rd_data;
  logic rd_oe, rd_empty, match_flag, full;
  logic [3:0] match_addr;

  always #4 clk = ~clk;

  tcam_cmd dut_i (.clk, .rst_n, .cmd_valid, .cmd_op, .cmd_msel, .cmd_data, .vb_n,
                  .page_id, .rd_data, .rd_oe, .rd_empty, .match_flag, .match_addr, .full);

  int checks = 0, errors = 0;
  logic [31:0] m_mem [16];
  bit m_occ [16];
  bit m_mv [16];
  logic [31:0] m_mask [8];
  int m_ar;
  bit e_oe, e_emp;
  logic [31:0] e_rd;

  function automatic int lowest_match();
    for (int i = 0; i < 16; i++) if (m_mv[i]) return i;
    return -1;
  endfunction
  function automatic int lowest_empty();
    for (int i = 0; i < 16; i++) if (!m_occ[i]) return i;
    return -1;
  endfunction

  task automatic check(string tag);
    int h = lowest_match();
    bit ef = (h >= 0);
    bit efull = (lowest_empty() < 0);
    checks++;
    if (rd_oe !== e_oe || (e_oe && (rd_data !== e_rd || rd_empty !== e_emp)) ||
        match_flag !== ef || (ef && match_addr !== 4'(h)) || full !== efull) begin
      errors++;
      $display("FAIL %s: oe=%0b data=%h emp=%0b flag=%0b addr=%0d full=%0b expected oe=%0b data=%h emp=%0b flag=%0b addr=%0d full=%0b",
               tag, rd_oe, rd_data, rd_empty, match_flag, match_addr, full,
               e_oe, e_rd, e_emp, ef, h, efull);
    end
  endtask

  task automatic model_write(int a, logic [31:0] m, logic [31:0] d, bit vbn);
    m_mem[a] = (m_mem[a] & m) | (d & ~m);
    m_occ[a] = !vbn;
  endtask

  task automatic step(bit v, logic [3:0] op, logic [2:0] ms, logic [31:0] d, bit vbn, string tag);
    logic [31:0] m;
    int h, nf;
    cmd_valid = v; cmd_op = op; cmd_msel = ms; cmd_data = d; vb_n = vbn;
    m = (ms == 0) ? 32'h0 : m_mask[ms];
    h = lowest_match(); nf = lowest_empty();
    e_oe = 0; e_emp = 0; e_rd = 'x;
    if (v) begin
      case (op)
        1: for (int i = 0; i < 16; i++) m_mv[i] = m_occ[i] && (m_mem[i] === d);
        2: begin e_oe = 1; e_rd = m_mem[m_ar]; e_emp = !m_occ[m_ar]; m_ar = (m_ar + 15) % 16; end
        3: model_write(m_ar, m, d, vbn);
        4, 5: if (h >= 0) begin
             e_oe = 1; e_rd = m_mem[h];
             if (op == 5) m_mv[h] = 0;
           end
        6: if (h >= 0) model_write(h, m, d, vbn);
        7: if (nf >= 0) model_write(nf, m, d, vbn);
        8: if (nf >= 0) begin e_oe = 1; e_rd = {16'h0, page_id, 12'(nf)}; end
        9: m_ar = ((m_ar & m[3:0]) | (d[3:0] & ~m[3:0])) & 15;
        10: begin e_oe = 1; e_rd = 32'(m_ar); end
        11: if (ms != 0) m_mask[ms] = d;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_occ[i] = 0; m_mv[i] = 0; m_mem[i] = 'x; end
    for (int i = 0; i < 8; i++) m_mask[i] = 0;
    m_ar = 0; e_oe = 0; e_emp = 0; e_rd = 'x;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check("R1 reset state");
    step(1, 4, 0, 0, 0, "R1 no match after reset");
    step(1, 11, 1, 32'hFFFF_0000, 0, "R2 load mask 1");
    step(1, 11, 2, 32'h0000_000F, 0, "R2 load mask 2");
    step(1, 11, 0, 32'h1234_5678, 0, "R2 selector 0 ignored");
    step(1, 7, 0, 32'hAAAA_0001, 0, "R8 write free slot 0");
    step(1, 7, 0, 32'hBBBB_0002, 0, "R8 write free slot 1");
    step(1, 7, 0, 32'hAAAA_0001, 0, "R8 write free slot 2");
    step(1, 7, 0, 32'hAAAA_0001, 1, "R3 write as empty");
    step(1, 8, 0, 0, 0, "R9 free index read");
    step(1, 1, 0, 32'hAAAA_0001, 0, "R5 compare duplicates");
    step(1, 4, 0, 0, 0, "R6 read best match");
    step(1, 5, 0, 0, 0, "R7 read and step");
    step(1, 5, 0, 0, 0, "R7 read last and exhaust");
    step(1, 4, 0, 0, 0, "R6 no match keeps oe low");
    step(1, 9, 0, 32'h0000_0001, 0, "R10 load address register");
    step(1, 10, 0, 0, 0, "R10 read address register");
    step(1, 9, 2, 32'h0000_0007, 0, "R10 fully masked load");
    step(1, 10, 0, 0, 0, "R10 readback after mask");
    step(1, 2, 0, 0, 0, "R4 read at address 1");
    step(1, 2, 0, 0, 0, "R4 read at address 0");
    step(1, 2, 0, 0, 0, "R4 wrap to 15");
    step(1, 3, 1, 32'h1111_2222, 0, "R4 masked write at address");
    step(1, 9, 0, 32'h0000_000E, 0, "R10 reposition");
    step(1, 2, 0, 0, 0, "R4 read back masked entry");
    step(1, 1, 0, 32'hBBBB_0002, 0, "R5 compare single");
    step(1, 6, 1, 32'hCCCC_CCCC, 0, "R12 masked write at match");
    step(1, 4, 0, 0, 0, "R12 match not recomputed");
    step(1, 6, 0, 32'h0, 1, "R12 invalidate at match");
    step(1, 1, 0, 32'hBBBB_CCCC, 0, "R5 emptied entry excluded");
    for (int i = 0; i < 16; i++) step(1, 7, 0, 32'h5000_0000 + i, 0, "R8 fill");
    step(1, 7, 0, 32'hDEAD_BEEF, 0, "R8 write when full ignored");
    step(1, 8, 0, 0, 0, "R9 free index when full");
    step(1, 0, 0, 32'hFFFF_FFFF, 0, "R11 nop");
    step(1, 13, 3, 32'hFFFF_FFFF, 0, "R11 undefined opcode");
    step(0, 7, 0, 32'hFFFF_FFFF, 0, "R11 idle cycle");
    for (int i = 0; i < 16; i++) step(1, 2, 0, 0, 0, "R8 contents intact");
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op = 4'($urandom_range(0, 15));
      logic [31:0] d = ($urandom_range(0, 3) == 0) ? 32'h5000_0003 : 32'($urandom_range(0, 7));
      if (op == 9 || op == 11) d = $urandom;
      step($urandom_range(0, 7) != 0, op, 3'($urandom_range(0, 7)), d,
           $urandom_range(0, 3) == 0, "R5 R7 R12 random mix");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule